// File: doc/BRIEF.md
# Fine-Adjustable Precision Time Counter

This block keeps the time of day for a precision time protocol clock as a free-running nanosecond count. On every cycle of its 8 ns clock it adds a fixed step of 8 ns. Below the nanosecond count sits a 32-bit fractional accumulator. On each cycle a signed correction is added to it, or subtracted from it. A carry out of the accumulator lengthens that cycle's step by one nanosecond, and a borrow shortens it by one. This lets software trim the clock rate in parts per billion without touching the nominal step.

Software works through a 32-bit word register port. Reading the fractional word takes a snapshot of the whole time, so the nanosecond low and high words read afterwards belong to the same instant. Writing the low nanosecond word only stages it. The high-word write then loads the full 40-bit time in a single cycle and zeroes the fraction. A phase step is done by software as read, add and write back. A halt bit in a control word freezes the counter and is set out of reset. The live time is also driven out on dedicated ports for a timestamp capture unit.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (halted), the rate word reads 0, the time words read 0, and `time_ns`, `time_frac` and `reg_rdata` are 0.
- R2: While control bit 31 is 1 the time (`time_ns`, `time_frac`) does not change except by a load. Writing 0 to the control word (address 4) makes the counter advance from the next cycle on.
- R3: With a rate word of 0 a running counter advances by exactly 8 ns per cycle and the fraction stays unchanged.
- R4: With rate bit 31 = 0 the magnitude in bits 30:0 (units of 2^-32 ns) is added to the fraction each cycle, and a carry out adds 1 ns to that cycle's 8 ns step.
- R5: With rate bit 31 = 1 the magnitude is subtracted from the fraction each cycle, and a borrow takes 1 ns off that cycle's 8 ns step.
- R6: The nanosecond count is 40 bits wide and wraps modulo 2^40. A read of the high word returns the count's bits 39:32 in bits 7:0 and zeros in bits 31:8.
- R7: Register reads use address 0 for the fraction, 1 for ns bits 31:0, 2 for ns high, 3 for rate and 4 for control, and return data on `reg_rdata` one cycle after the read strobe. A read of address 0 returns the fraction as it stood in the strobe cycle and captures the nanosecond count of that cycle. Reads of addresses 1 and 2 return the latest capture, and a new address-0 read replaces it.
- R8: A write to address 1 only stages its data and leaves the time unchanged. A write to address 2 loads {wdata[7:0], staged word} into the count in that cycle, clears the fraction, and takes priority over the advance of that cycle.
- R9: The rate word (address 3) and control bit 31 (address 4) read back as written. A write to address 0 has no effect.
- R10: `time_ns` and `time_frac` always show the live count and fraction, updated at the same clock edge as the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz time base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| time_ns | output | 40 | Live nanosecond count for timestamp capture |
| time_frac | output | 32 | Live sub-nanosecond fraction |

## Verification
Two functions can fall in the same cycle here. A high-word load can meet an accumulator carry, and a snapshot capture can meet a counter advance. To provoke the first, the bench runs at the largest positive rate, waits until the live fraction is high enough that the current cycle must carry, and issues the high-word write in that cycle. The loaded time must appear exactly, with a zero fraction and no extra nanosecond, and the following step must be a plain 8 ns. For the second, captures are taken while the counter runs, and the returned words are judged against the time the ports showed in the strobe cycle, not the time after the edge.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

  // Word addresses of the register port
  typedef enum logic [2:0] {
    TOD_SUB  = 3'd0,
    TOD_NSLO = 3'd1,
    TOD_NSHI = 3'd2,
    TOD_RATE = 3'd3,
    TOD_CTRL = 3'd4
  } tod_addr_e;

endpackage

// File: rtl/tod_frac_accum.sv
module tod_frac_accum #(
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              clr,
  input  logic              neg,
  input  logic [FRAC_W-2:0] mag,
  output logic [FRAC_W-1:0] frac,
  output logic              carry,
  output logic              borrow
);

  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [FRAC_W:0]   sum_w, dif_w;

  always_comb begin
    sum_w  = {1'b0, frac_q} + {2'b00, mag};
    dif_w  = {1'b0, frac_q} - {2'b00, mag};
    carry  = 1'b0;
    borrow = 1'b0;
    frac_d = frac_q;
    if (clr) begin
      frac_d = '0;
    end else if (adv_en) begin
      if (neg) begin
        frac_d = dif_w[FRAC_W-1:0];
        borrow = dif_w[FRAC_W];
      end else begin
        frac_d = sum_w[FRAC_W-1:0];
        carry  = sum_w[FRAC_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end

  assign frac = frac_q;

endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter #(
  parameter int NS_W     = 40,
  parameter int NOM_STEP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_en,
  input  logic            load_en,
  input  logic [NS_W-1:0] load_val,
  input  logic            carry,
  input  logic            borrow,
  output logic [NS_W-1:0] ns
);

  localparam logic [NS_W-1:0] STEP = NS_W'(NOM_STEP);

  logic [NS_W-1:0] ns_q, ns_d;

  always_comb begin
    ns_d = ns_q;
    if (load_en)     ns_d = load_val;
    else if (adv_en) ns_d = ns_q + STEP + NS_W'(carry) - NS_W'(borrow);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ns_q <= '0;
    else        ns_q <= ns_d;
  end

  assign ns = ns_q;

endmodule

// File: rtl/tod_reg_if.sv
module tod_reg_if
  import ptp_tod_pkg::*;
#(
  parameter int NS_W   = 40,
  parameter int FRAC_W = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [NS_W-1:0]   live_ns,
  input  logic [FRAC_W-1:0] live_frac,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              halt,
  output logic              rate_neg,
  output logic [FRAC_W-2:0] rate_mag,
  output logic              load_en,
  output logic [NS_W-1:0]   load_val
);

  localparam int HI_W = NS_W - REG_W;

  logic [REG_W-1:0] stage_lo_q, stage_lo_d;
  logic [NS_W-1:0]  shadow_q, shadow_d;
  logic [REG_W-1:0] rate_q, rate_d;
  logic             halt_q, halt_d;
  logic [REG_W-1:0] rdata_q, rdata_d;
  logic             wr_lo, wr_rate, wr_ctrl, rd_sub;

  always_comb begin
    wr_lo    = reg_wr && (reg_addr == TOD_NSLO);
    wr_rate  = reg_wr && (reg_addr == TOD_RATE);
    wr_ctrl  = reg_wr && (reg_addr == TOD_CTRL);
    rd_sub   = reg_rd && (reg_addr == TOD_SUB);
    load_en  = reg_wr && (reg_addr == TOD_NSHI);
    load_val = {reg_wdata[HI_W-1:0], stage_lo_q};

    stage_lo_d = stage_lo_q;
    if (wr_lo) stage_lo_d = reg_wdata;

    rate_d = rate_q;
    if (wr_rate) rate_d = reg_wdata;

    halt_d = halt_q;
    if (wr_ctrl) halt_d = reg_wdata[REG_W-1];

    shadow_d = shadow_q;
    if (rd_sub) shadow_d = live_ns;

    rdata_d = rdata_q;
    if (reg_rd) begin
      case (reg_addr)
        TOD_SUB:  rdata_d = live_frac;
        TOD_NSLO: rdata_d = shadow_q[REG_W-1:0];
        TOD_NSHI: rdata_d = {{(REG_W-HI_W){1'b0}}, shadow_q[NS_W-1:REG_W]};
        TOD_RATE: rdata_d = rate_q;
        TOD_CTRL: rdata_d = {halt_q, {(REG_W-1){1'b0}}};
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo_q <= '0;
      shadow_q   <= '0;
      rate_q     <= '0;
      halt_q     <= 1'b1;
      rdata_q    <= '0;
    end else begin
      stage_lo_q <= stage_lo_d;
      shadow_q   <= shadow_d;
      rate_q     <= rate_d;
      halt_q     <= halt_d;
      rdata_q    <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign halt      = halt_q;
  assign rate_neg  = rate_q[REG_W-1];
  assign rate_mag  = rate_q[FRAC_W-2:0];

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int NS_W     = 40,
  parameter int FRAC_W   = 32,
  parameter int REG_W    = 32,
  parameter int NOM_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NS_W-1:0]   time_ns,
  output logic [FRAC_W-1:0] time_frac
);

  logic              halt_w;
  logic              rate_neg_w;
  logic [FRAC_W-2:0] rate_mag_w;
  logic              load_w;
  logic [NS_W-1:0]   load_val_w;
  logic              adv_w;
  logic              carry_w, borrow_w;
  logic [NS_W-1:0]   ns_w;
  logic [FRAC_W-1:0] frac_w;

  // a load wins over the advance of the same cycle
  assign adv_w = !halt_w && !load_w;

  tod_reg_if #(.NS_W(NS_W), .FRAC_W(FRAC_W), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .live_ns   (ns_w),
    .live_frac (frac_w),
    .reg_rdata (reg_rdata),
    .halt      (halt_w),
    .rate_neg  (rate_neg_w),
    .rate_mag  (rate_mag_w),
    .load_en   (load_w),
    .load_val  (load_val_w)
  );

  tod_frac_accum #(.FRAC_W(FRAC_W)) u_frac (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (adv_w),
    .clr    (load_w),
    .neg    (rate_neg_w),
    .mag    (rate_mag_w),
    .frac   (frac_w),
    .carry  (carry_w),
    .borrow (borrow_w)
  );

  tod_ns_counter #(.NS_W(NS_W), .NOM_STEP(NOM_STEP)) u_ns (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (adv_w),
    .load_en  (load_w),
    .load_val (load_val_w),
    .carry    (carry_w),
    .borrow   (borrow_w),
    .ns       (ns_w)
  );

  assign time_ns   = ns_w;
  assign time_frac = frac_w;

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int NS_W     = 40,
  parameter int FRAC_W   = 32,
  parameter int REG_W    = 32,
  parameter int NOM_STEP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [2:0]        reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [NS_W-1:0]   time_ns,
  input logic [FRAC_W-1:0] time_frac,
  input logic              halt,
  input logic [FRAC_W-2:0] rate_mag
);

  logic [NS_W-1:0]   prev_ns;
  logic [FRAC_W-1:0] prev_frac;
  logic              prev_halt, prev_load, prev_zero;
  logic              prev_rd_sub, prev_rd_lo, prev_rd_hi;
  logic [NS_W-1:0]   cap_ns;
  logic [NS_W-1:0]   delta;
  logic              prev_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ns     <= '0;
      prev_frac   <= '0;
      prev_halt   <= 1'b1;
      prev_load   <= 1'b0;
      prev_zero   <= 1'b1;
      prev_rd_sub <= 1'b0;
      prev_rd_lo  <= 1'b0;
      prev_rd_hi  <= 1'b0;
      cap_ns      <= '0;
    end else begin
      prev_ns     <= time_ns;
      prev_frac   <= time_frac;
      prev_halt   <= halt;
      prev_load   <= reg_wr && (reg_addr == 3'd2);
      prev_zero   <= (rate_mag == '0);
      prev_rd_sub <= reg_rd && (reg_addr == 3'd0);
      prev_rd_lo  <= reg_rd && (reg_addr == 3'd1);
      prev_rd_hi  <= reg_rd && (reg_addr == 3'd2);
      if (reg_rd && (reg_addr == 3'd0)) cap_ns <= time_ns;
    end
  end

  assign delta    = time_ns - prev_ns;
  assign prev_run = !prev_halt && !prev_load;

  // R3
  nominal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_run && prev_zero) |-> (delta == NS_W'(NOM_STEP)));

  // R4 R5
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_run |-> ((delta >= NS_W'(NOM_STEP - 1)) && (delta <= NS_W'(NOM_STEP + 1))));

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_halt && !prev_load) |-> ((time_ns == prev_ns) && (time_frac == prev_frac)));

  // R8
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_load |-> (time_frac == '0));

  // R7
  sub_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_rd_sub |-> (reg_rdata == prev_frac));

  // R7
  lo_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_rd_lo |-> (reg_rdata == cap_ns[REG_W-1:0]));

  // R6
  hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_rd_hi |-> (reg_rdata == {{(2*REG_W-NS_W){1'b0}}, cap_ns[NS_W-1:REG_W]}));

endmodule

bind ptp_tod_counter tod_counter_chk #(
  .NS_W(NS_W), .FRAC_W(FRAC_W), .REG_W(REG_W), .NOM_STEP(NOM_STEP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .time_ns   (time_ns),
  .time_frac (time_frac),
  .halt      (halt_w),
  .rate_mag  (rate_mag_w)
);

// File: tb/sim_ptp_tod_counter.sv
module sim_ptp_tod_counter;

  localparam int CLK_PERIOD = 8;
  localparam int NV = 6;

  localparam logic [2:0] A_SUB = 3'd0, A_LO = 3'd1, A_HI = 3'd2, A_RATE = 3'd3, A_CTRL = 3'd4;

  // stimulus: start time, rate word, cycles run; expected: ns, fraction
  localparam logic [39:0] V_START [NV] = '{40'h0, 40'd100, 40'd1000, 40'hFF_FFFF_FFF0,
                                          40'h12_3456_7890, 40'h0};
  localparam logic [31:0] V_RATE  [NV] = '{32'h0, 32'h4000_0000, 32'hC000_0000, 32'h0,
                                          32'h7FFF_FFFF, 32'h8000_0001};
  localparam int          V_N     [NV] = '{10, 8, 3, 3, 4, 2};
  localparam logic [39:0] V_ENS   [NV] = '{40'd80, 40'd166, 40'd1023, 40'd8,
                                          40'h12_3456_78B1, 40'd15};
  localparam logic [31:0] V_EFR   [NV] = '{32'h0, 32'h0, 32'h4000_0000, 32'h0,
                                          32'hFFFF_FFFC, 32'hFFFF_FFFE};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [39:0] time_ns;
  logic [31:0] time_frac;

  int n_chk = 0;
  int n_fail = 0;
  logic [39:0] pre_ns;
  logic [31:0] pre_frac;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_tod_counter u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns), .time_frac(time_frac)
  );

  function automatic string vtag(input int i);
    case (i)
      0: return "R3 nominal step";
      1: return "R4 carry";
      2: return "R5 borrow";
      3: return "R6 wrap";
      4: return "R4 near-max rate";
      default: return "R5 borrow from zero";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic rd, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    pre_ns    = time_ns;
    pre_frac  = time_frac;
    reg_wr    = wr;
    reg_rd    = rd;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    bus(1'b1, 1'b0, a, d);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] q);
    bus(1'b0, 1'b1, a, 32'h0);
    q = reg_rdata;
  endtask

  // exactly n advances, then halted again
  task automatic run(input int n);
    wr_reg(A_CTRL, 32'h0);
    repeat (n - 1) @(posedge clk);
    wr_reg(A_CTRL, 32'h8000_0000);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] f, lo, hi, q;
    logic [39:0] snap, hold;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 rdata", {32'h0, reg_rdata}, 64'h0);
    check("R1 time_ns", {24'h0, time_ns}, 64'h0);
    check("R1 time_frac", {32'h0, time_frac}, 64'h0);
    rd_reg(A_CTRL, q); check("R1 ctrl halted", {32'h0, q}, 64'h8000_0000);
    rd_reg(A_RATE, q); check("R1 rate", {32'h0, q}, 64'h0);
    rd_reg(A_SUB, f); rd_reg(A_LO, lo); rd_reg(A_HI, hi);
    check("R1 time words", {f, lo ^ hi}, 64'h0);
    repeat (5) @(posedge clk);
    #1 check("R2 halted after reset", {24'h0, time_ns}, 64'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr_reg(A_LO, V_START[i][31:0]);
      wr_reg(A_HI, {24'h0, V_START[i][39:32]});
      wr_reg(A_RATE, V_RATE[i]);
      run(V_N[i]);
      rd_reg(A_SUB, f); rd_reg(A_LO, lo); rd_reg(A_HI, hi);
      check(vtag(i), {hi, lo}, {24'h0, V_ENS[i]});
      check(vtag(i), {32'h0, f}, {32'h0, V_EFR[i]});
    end

    // R9 readback and ignored fraction write
    wr_reg(A_RATE, 32'h8000_1234);
    rd_reg(A_RATE, q); check("R9 rate readback", {32'h0, q}, 64'h8000_1234);
    wr_reg(A_LO, 32'h55); wr_reg(A_HI, 32'h0);
    wr_reg(A_SUB, 32'hDEAD_BEEF);
    rd_reg(A_SUB, f); check("R9 fraction write ignored", {32'h0, f}, 64'h0);

    // R8 staging, load, high-bit masking
    hold = time_ns;
    wr_reg(A_LO, 32'h1111);
    check("R8 staged low write no effect", {24'h0, time_ns}, {24'h0, hold});
    wr_reg(A_HI, 32'hFFFF_FF03);
    check("R10 export after load", {24'h0, time_ns}, 64'h03_0000_1111);
    rd_reg(A_SUB, f); rd_reg(A_HI, hi);
    check("R6 high word padding", {32'h0, hi}, 64'h3);

    // R7 coherent snapshot while running
    wr_reg(A_RATE, 32'h0010_0000);
    wr_reg(A_CTRL, 32'h0);
    rd_reg(A_SUB, f);
    snap = pre_ns;
    check("R7 fraction at strobe", {32'h0, f}, {32'h0, pre_frac});
    repeat (7) @(posedge clk);
    rd_reg(A_LO, lo); rd_reg(A_HI, hi);
    check("R7 snapshot words", {hi, lo}, {24'h0, snap});
    check("R10 live time moved on", {63'h0, (time_ns != snap)}, 64'h1);
    rd_reg(A_SUB, f);
    rd_reg(A_SUB, f);
    snap = pre_ns;
    rd_reg(A_LO, lo);
    check("R7 recapture", {32'h0, lo}, {32'h0, snap[31:0]});

    // R8 load meets a carry in the same cycle
    wr_reg(A_RATE, 32'h7FFF_FFFF);
    wr_reg(A_LO, 32'hABCD_0000);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (time_frac >= 32'h8000_0001) break;
    end
    reg_wr = 1'b1; reg_addr = A_HI; reg_wdata = 32'h12;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    check("R8 load wins over carry", {24'h0, time_ns}, 64'h12_ABCD_0000);
    check("R8 load clears fraction", {32'h0, time_frac}, 64'h0);
    @(posedge clk);
    #1 check("R4 step after load", {time_frac, 24'h0, time_ns[39:32]}, {32'h7FFF_FFFF, 32'h12});
    check("R4 step after load low", {32'h0, time_ns[31:0]}, 64'hABCD_0008);

    // R2 halt freezes
    wr_reg(A_CTRL, 32'h8000_0000);
    hold = time_ns;
    f = time_frac;
    repeat (5) @(posedge clk);
    #1 check("R2 halt holds ns", {24'h0, time_ns}, {24'h0, hold});
    check("R2 halt holds fraction", {32'h0, time_frac}, {32'h0, f});
    rd_reg(A_CTRL, q); check("R9 ctrl readback", {32'h0, q}, 64'h8000_0000);

    summary();
    $finish;
  end

endmodule